// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic unit of an 8-bit accumulator machine. Each cycle it receives an operation code, the current accumulator value, a second operand (a register, a memory byte or an immediate already fetched by the surrounding core) and the current five-bit flag word. From these it computes a new accumulator value and a new flag word. Both are captured in output registers on a rising clock edge while the enable input is high.

Each operation class follows its own flag rule. Binary arithmetic rewrites all five flags. Increment and decrement keep the carry. The logic operations force the carry and auxiliary-carry bits to fixed values. Complement keeps every flag. The four rotates write only the carry. A decimal-adjust step turns the sum of two packed-BCD bytes back into packed BCD.

Top module: `acc_alu8`

## Requirements
- R1: With `rst` high at a rising clock edge, `res_q` and `flags_q` become zero on that edge. This takes priority over `en`.
- R2: With `en` low and `rst` low at a rising edge, `res_q` and `flags_q` keep their values whatever the other inputs do.
- R3: The flag word holds Sign in bit 4, Zero in bit 3, Aux-carry in bit 2, Parity in bit 1 and Carry in bit 0. Code 0 (add) and code 1 (add with carry in, taken from `flags_in[0]`) give `acc_in + opnd_in`. Carry is the carry out of bit 7 and Aux-carry is the carry out of bit 3.
- R4: Code 2 (subtract) and code 3 (subtract with borrow in, taken from `flags_in[0]`) give `acc_in - opnd_in`. Carry is set when a borrow out of bit 7 occurs. Aux-carry is set when the low nibble borrows.
- R5: Every operation that updates the status flags sets Sign to bit 7 of the result, sets Zero when the result is 00h, and sets Parity when the result has an even number of one bits.
- R6: Code 4 gives `opnd_in + 1` and code 5 gives `opnd_in - 1`. Aux-carry shows the low-nibble carry or borrow. Carry is copied unchanged from `flags_in[0]`.
- R7: Code 6 gives `acc_in & opnd_in`, with Aux-carry forced to 1 and Carry forced to 0.
- R8: Code 7 (OR) and code 8 (XOR) combine `acc_in` and `opnd_in`, with both Aux-carry and Carry forced to 0.
- R9: Code 9 gives the bitwise inverse of `acc_in`, and the flag word is copied unchanged from `flags_in`.
- R10: Code 10 (decimal adjust) works in two steps. First it adds 06h when the low nibble of `acc_in` is above 9 or the incoming Aux-carry is set; Aux-carry then becomes the carry out of bit 3 of that addition. Next it adds 60h when the high nibble after the first step is above 9, when the first step carried out of bit 7, or when the incoming Carry is set. In that case Carry is set; otherwise Carry keeps its incoming value.
- R11: Code 11 rotates `acc_in` left and code 12 rotates it right, each with the bit that leaves also written to Carry. Code 13 rotates left and code 14 rotates right through Carry.
- R12: The rotates (codes 11 to 14) keep Sign, Zero, Aux-carry and Parity unchanged from `flags_in`.
- R13: Code 15 passes `acc_in` to the result and copies `flags_in` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Load enable for both output registers |
| op_code | input | 4 | Operation select, codes 0 to 15 |
| acc_in | input | 8 | Current accumulator value |
| opnd_in | input | 8 | Second operand |
| flags_in | input | 5 | Current flag word {S,Z,AC,P,CY} |
| res_q | output | 8 | Registered new accumulator value |
| flags_q | output | 5 | Registered new flag word |

## Verification
The hardest paths to reach are in the decimal adjust. One is the case where the first +06h step overflows bit 7 or pushes the high nibble past 9, so that the second correction triggers only because of the first. The other is the case where only the incoming Aux-carry, and not the nibble value, triggers the low correction. The vector table drives these directly through `acc_in` and `flags_in`, with values such as 9Ah and 22h carrying a set Aux-carry. The rotate-through-carry forms are checked with the incoming carry set and then cleared, so they can be told apart from the plain rotates.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  parameter int DATA_W = 8;
  parameter int FLAG_W = 5;
  parameter int OP_W   = 4;

  localparam int F_S  = 4;
  localparam int F_Z  = 3;
  localparam int F_AC = 2;
  localparam int F_P  = 1;
  localparam int F_CY = 0;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_CPL  = 4'd9,
    OP_DAA  = 4'd10,
    OP_ROLC = 4'd11,
    OP_RORC = 4'd12,
    OP_ROLT = 4'd13,
    OP_RORT = 4'd14,
    OP_PASS = 4'd15
  } alu_op_e;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic            cy_in,
  input  logic            ac_in,
  output logic [W-1:0]    res,
  output logic            cy_out,
  output logic            ac_out
);
  localparam int NB = 4;

  logic          use_c;
  logic [W:0]    full;
  logic [NB:0]   low;
  logic          lo_fix, hi_fix;
  logic [W:0]    step1, step2;
  logic [NB:0]   lo_adj;

  always_comb begin
    use_c  = 1'b0;
    full   = '0;
    low    = '0;
    res    = '0;
    cy_out = cy_in;
    ac_out = 1'b0;
    lo_fix = 1'b0;
    hi_fix = 1'b0;
    step1  = '0;
    step2  = '0;
    lo_adj = '0;
    case (op)
      OP_ADD, OP_ADC: begin
        use_c  = (op == OP_ADC) && cy_in;
        full   = {1'b0, a} + {1'b0, b} + (W+1)'(use_c);
        low    = {1'b0, a[NB-1:0]} + {1'b0, b[NB-1:0]} + (NB+1)'(use_c);
        res    = full[W-1:0];
        cy_out = full[W];
        ac_out = low[NB];
      end
      OP_SUB, OP_SBB: begin
        use_c  = (op == OP_SBB) && cy_in;
        full   = {1'b0, a} - {1'b0, b} - (W+1)'(use_c);
        low    = {1'b0, a[NB-1:0]} - {1'b0, b[NB-1:0]} - (NB+1)'(use_c);
        res    = full[W-1:0];
        cy_out = full[W];
        ac_out = low[NB];
      end
      OP_INC: begin
        res    = b + W'(1);
        ac_out = (b[NB-1:0] == {NB{1'b1}});
      end
      OP_DEC: begin
        res    = b - W'(1);
        ac_out = (b[NB-1:0] == '0);
      end
      OP_DAA: begin
        lo_fix = (a[NB-1:0] > NB'(9)) || ac_in;
        lo_adj = {1'b0, a[NB-1:0]} + (NB+1)'(6);
        step1  = {1'b0, a} + (lo_fix ? (W+1)'(6) : '0);
        hi_fix = step1[W] || (step1[W-1:NB] > (W-NB)'(9)) || cy_in;
        step2  = step1 + (hi_fix ? (W+1)'(8'h60) : '0);
        res    = step2[W-1:0];
        ac_out = lo_fix && lo_adj[NB];
        cy_out = hi_fix;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic            cy_in,
  output logic [W-1:0]    res,
  output logic            cy_out
);
  always_comb begin
    res    = a;
    cy_out = cy_in;
    case (op)
      OP_AND:  begin res = a & b; cy_out = 1'b0; end
      OP_OR:   begin res = a | b; cy_out = 1'b0; end
      OP_XOR:  begin res = a ^ b; cy_out = 1'b0; end
      OP_CPL:  res = ~a;
      OP_ROLC: begin res = {a[W-2:0], a[W-1]}; cy_out = a[W-1]; end
      OP_RORC: begin res = {a[0], a[W-1:1]};   cy_out = a[0];   end
      OP_ROLT: begin res = {a[W-2:0], cy_in};  cy_out = a[W-1]; end
      OP_RORT: begin res = {cy_in, a[W-1:1]};  cy_out = a[0];   end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
  import alu8_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int FW = FLAG_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [OP_W-1:0] op_code,
  input  logic [W-1:0]    acc_in,
  input  logic [W-1:0]    opnd_in,
  input  logic [FW-1:0]   flags_in,
  output logic [W-1:0]    res_q,
  output logic [FW-1:0]   flags_q
);
  logic [W-1:0]  ar_res, lg_res, nxt_res;
  logic          ar_cy, ar_ac, lg_cy;
  logic [FW-1:0] nxt_fl;

  alu8_arith #(.W(W)) u_arith (
    .op(op_code), .a(acc_in), .b(opnd_in),
    .cy_in(flags_in[F_CY]), .ac_in(flags_in[F_AC]),
    .res(ar_res), .cy_out(ar_cy), .ac_out(ar_ac)
  );

  alu8_logic #(.W(W)) u_logic (
    .op(op_code), .a(acc_in), .b(opnd_in),
    .cy_in(flags_in[F_CY]),
    .res(lg_res), .cy_out(lg_cy)
  );

  always_comb begin
    nxt_fl = flags_in;
    case (op_code)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_INC, OP_DEC, OP_DAA: begin
        nxt_res        = ar_res;
        nxt_fl[F_S]    = ar_res[W-1];
        nxt_fl[F_Z]    = (ar_res == '0);
        nxt_fl[F_P]    = ~^ar_res;
        nxt_fl[F_AC]   = ar_ac;
        nxt_fl[F_CY]   = ar_cy;
      end
      OP_AND, OP_OR, OP_XOR: begin
        nxt_res        = lg_res;
        nxt_fl[F_S]    = lg_res[W-1];
        nxt_fl[F_Z]    = (lg_res == '0);
        nxt_fl[F_P]    = ~^lg_res;
        nxt_fl[F_AC]   = (op_code == OP_AND);
        nxt_fl[F_CY]   = lg_cy;
      end
      OP_ROLC, OP_RORC, OP_ROLT, OP_RORT: begin
        nxt_res        = lg_res;
        nxt_fl[F_CY]   = lg_cy;
      end
      default: nxt_res = lg_res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      flags_q <= '0;
    end else if (en) begin
      res_q   <= nxt_res;
      flags_q <= nxt_fl;
    end
  end

  // R1: reset wins over enable
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (res_q == '0 && flags_q == '0));

  // R2: registers hold while disabled
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(res_q) && $stable(flags_q)));

  // R5: parity flag agrees with the stored result for arithmetic/logic classes
  p_parity_r5: assert property (@(posedge clk) disable iff (rst)
    (en && (op_code <= OP_XOR || op_code == OP_DAA)) |=>
      (flags_q[F_P] == ~^res_q && flags_q[F_Z] == (res_q == '0)));

  // R6: increment/decrement keep carry
  p_incdec_cy_r6: assert property (@(posedge clk) disable iff (rst)
    (en && (op_code == OP_INC || op_code == OP_DEC)) |=>
      flags_q[F_CY] == $past(flags_in[F_CY]));

  // R7: AND forces AC=1, CY=0
  p_and_flags_r7: assert property (@(posedge clk) disable iff (rst)
    (en && op_code == OP_AND) |=> (flags_q[F_AC] && !flags_q[F_CY]));

  // R8: OR/XOR clear AC and CY
  p_orxor_flags_r8: assert property (@(posedge clk) disable iff (rst)
    (en && (op_code == OP_OR || op_code == OP_XOR)) |=>
      (!flags_q[F_AC] && !flags_q[F_CY]));

  // R9: complement keeps every flag
  p_cpl_flags_r9: assert property (@(posedge clk) disable iff (rst)
    (en && op_code == OP_CPL) |=> flags_q == $past(flags_in));

  // R12: rotates keep S, Z, AC, P
  p_rot_keep_r12: assert property (@(posedge clk) disable iff (rst)
    (en && op_code >= OP_ROLC && op_code <= OP_RORT) |=>
      flags_q[FW-1:F_P] == $past(flags_in[FW-1:F_P]));
endmodule

// File: tb/acc_alu8_tb.sv
`timescale 1ns/1ps
module acc_alu8_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [3:0] op_code = '0;
  logic [7:0] acc_in = '0, opnd_in = '0;
  logic [4:0] flags_in = '0;
  logic [7:0] res_q;
  logic [4:0] flags_q;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  acc_alu8 u_dut (
    .clk(clk), .rst(rst), .en(en), .op_code(op_code),
    .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
    .res_q(res_q), .flags_q(flags_q)
  );

  // {req, op, acc, opnd, flags_in, exp_res, exp_flags}; flags = {S,Z,AC,P,CY}
  localparam int NV = 26;
  localparam logic [41:0] VECS [NV] = '{
    {4'd3,  4'd0,  8'h9A, 8'h89, 5'b00000, 8'h23, 5'b00101}, // R3 add
    {4'd3,  4'd1,  8'h9A, 8'h89, 5'b00001, 8'h24, 5'b00111}, // R3 add with carry
    {4'd5,  4'd0,  8'h80, 8'h80, 5'b00000, 8'h00, 5'b01011}, // R5 zero result
    {4'd4,  4'd2,  8'h05, 8'h13, 5'b00000, 8'hF2, 5'b10001}, // R4 borrow
    {4'd4,  4'd2,  8'h20, 8'h08, 5'b00000, 8'h18, 5'b00110}, // R4 nibble borrow
    {4'd4,  4'd3,  8'h40, 8'h20, 5'b00001, 8'h1F, 5'b00100}, // R4 sub with borrow
    {4'd5,  4'd2,  8'h3C, 8'h3C, 5'b00000, 8'h00, 5'b01010}, // R5 equal operands
    {4'd6,  4'd4,  8'h11, 8'hFF, 5'b00001, 8'h00, 5'b01111}, // R6 inc wrap keeps CY
    {4'd6,  4'd5,  8'h11, 8'h00, 5'b00000, 8'hFF, 5'b10110}, // R6 dec wrap
    {4'd6,  4'd4,  8'h00, 8'h1C, 5'b00000, 8'h1D, 5'b00010}, // R6 inc
    {4'd7,  4'd6,  8'h62, 8'h4A, 5'b00001, 8'h42, 5'b00110}, // R7 and
    {4'd7,  4'd6,  8'h62, 8'h15, 5'b00000, 8'h00, 5'b01110}, // R7 and zero
    {4'd8,  4'd7,  8'h62, 8'h15, 5'b11111, 8'h77, 5'b00010}, // R8 or
    {4'd8,  4'd8,  8'hEE, 8'h5A, 5'b00101, 8'hB4, 5'b10010}, // R8 xor
    {4'd9,  4'd9,  8'h9A, 8'h00, 5'b10101, 8'h65, 5'b10101}, // R9 complement
    {4'd10, 4'd10, 8'h6C, 8'h00, 5'b00000, 8'h72, 5'b00110}, // R10 low fix
    {4'd10, 4'd10, 8'h99, 8'h00, 5'b00000, 8'h99, 5'b10010}, // R10 no fix
    {4'd10, 4'd10, 8'h9A, 8'h00, 5'b00000, 8'h00, 5'b01111}, // R10 cascaded fix
    {4'd10, 4'd10, 8'h22, 8'h00, 5'b00100, 8'h28, 5'b00010}, // R10 AC-driven fix
    {4'd10, 4'd10, 8'h12, 8'h00, 5'b00001, 8'h72, 5'b00011}, // R10 CY-driven fix
    {4'd11, 4'd11, 8'h85, 8'h00, 5'b11010, 8'h0B, 5'b11011}, // R11 R12 rotate left
    {4'd11, 4'd12, 8'h84, 8'h00, 5'b00001, 8'h42, 5'b00000}, // R11 rotate right
    {4'd11, 4'd13, 8'h85, 8'h00, 5'b00000, 8'h0A, 5'b00001}, // R11 left through CY
    {4'd11, 4'd14, 8'h84, 8'h00, 5'b00001, 8'hC2, 5'b00000}, // R11 right through CY
    {4'd12, 4'd13, 8'h7F, 8'h00, 5'b10101, 8'hFF, 5'b10100}, // R12 flags kept
    {4'd13, 4'd15, 8'h5A, 8'h33, 5'b10101, 8'h5A, 5'b10101}  // R13 pass
  };

  task automatic check(input string tag, input logic [7:0] r_exp, input logic [4:0] f_exp);
    n_checks++;
    if (res_q !== r_exp) begin
      n_errors++;
      $display("FAIL %s result: actual %h expected %h", tag, res_q, r_exp);
    end
    n_checks++;
    if (flags_q !== f_exp) begin
      n_errors++;
      $display("FAIL %s flags: actual %b expected %b", tag, flags_q, f_exp);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic [4:0] f);
    op_code = o; acc_in = a; opnd_in = b; flags_in = f;
  endtask

  initial begin
    #(5.0 * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    check("R1 reset", 8'h00, 5'b00000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i][37:34], VECS[i][33:26], VECS[i][25:18], VECS[i][17:13]);
      en = 1'b1;
      @(negedge clk);
      tag = $sformatf("R%0d vec%0d", VECS[i][41:38], i);
      check(tag, VECS[i][12:5], VECS[i][4:0]);
    end

    // R2: disabled, inputs change, outputs keep last vector
    @(negedge clk);
    en = 1'b0;
    drive(4'd0, 8'hFF, 8'h01, 5'b00000);
    repeat (3) @(negedge clk);
    check("R2 hold", 8'h5A, 5'b10101);

    // R1: reset overrides enable
    @(negedge clk);
    drive(4'd9, 8'h00, 8'h00, 5'b11111);
    en = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset over enable", 8'h00, 5'b00000);
    rst = 1'b0;
    @(negedge clk);
    check("R9 after reset", 8'hFF, 5'b11111);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule